// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit compares two IEEE-754 single-precision operands and turns the outcome into a condition-flag word. The outcome is one of greater, less, equal or unordered, and it is reduced to a three-bit zero/parity/carry code. The overflow, sign and auxiliary flags in the same word are always written as 0. The operand order matters. "Greater" means the first operand (`op_a`) is greater than the second (`op_b`).

A mode bit picks the NaN policy. The ordered mode treats any NaN as an invalid operation. The unordered mode treats only a signaling NaN as invalid. An invalid operation pulses `inv_exc` and sets a sticky status bit. When the exception mask is clear, the flag write is suppressed and the flag word keeps its old value. When the mask is set, the flags are written as usual. The result appears one cycle after the input strobe, together with an output strobe.

Top module: `fcmp_flags`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered. Unordered is coded as zero, parity, carry = 1,1,1.
- R2: For ordered operands, comparing `op_a` against `op_b` gives these zero/parity/carry codes: greater 0,0,0; less 0,0,1; equal 1,0,0.
- R3: `flags` is laid out as bit0 carry, bit1 parity, bit2 zero, bit3 auxiliary, bit4 sign, bit5 overflow. Bits 5..3 are 0 after every write.
- R4: In ordered mode (`unord_mode`=0), a quiet or signaling NaN in either operand raises `inv_exc`.
- R5: In unordered mode (`unord_mode`=1), `inv_exc` is raised only for a signaling NaN, which is a NaN with fraction MSB 0. A quiet NaN, with fraction MSB 1, raises nothing.
- R6: When `inv_exc` is raised and `inv_mask` is 0, `flags_we` stays 0 and `flags` keeps its previous value.
- R7: When `inv_mask` is 1, an invalid compare still writes the flags and raises `inv_exc`. Every invalid compare sets `inv_sticky`. `inv_sticky` clears only on `sticky_clr` or reset, and a new invalid compare in the same cycle takes priority over the clear.
- R8: Positive zero and negative zero compare equal. Infinities and subnormals compare by exact signed value, with no flushing to zero.
- R9: A compare strobed by `in_valid` at one clock edge produces `out_valid`, `flags_we`, `inv_exc` and the new `flags` after that same edge, for one cycle.
- R10: After reset, `flags` is 0 and `inv_sticky`, `out_valid`, `flags_we` and `inv_exc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid strobe |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| unord_mode | input | 1 | 0 = ordered NaN policy, 1 = unordered NaN policy |
| inv_mask | input | 1 | 1 = invalid exception masked |
| sticky_clr | input | 1 | Clears the sticky invalid bit |
| out_valid | output | 1 | Result strobe |
| flags_we | output | 1 | Flag word was written this cycle |
| flags | output | 6 | Held flag word |
| inv_exc | output | 1 | Invalid-operation pulse |
| inv_sticky | output | 1 | Sticky invalid status |

## Verification
A wrong compare key or a wrong NaN class shows up at the ports in the very next cycle. It appears as a wrong three-bit code in `flags`, or as a wrong `inv_exc` beside `out_valid`. A corrupted flag register or sticky bit is more dangerous because it persists. It is only exposed when a suppressed write should have left `flags` unchanged, or when `inv_sticky` is read after later clean compares. For that reason the tests chain scenarios and check the held state across them.

// File: rtl/fcmp_flags.sv
module fcmp_flags #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [EXP_W+MAN_W:0]       op_a,
  input  logic [EXP_W+MAN_W:0]       op_b,
  input  logic                       unord_mode,
  input  logic                       inv_mask,
  input  logic                       sticky_clr,
  output logic                       out_valid,
  output logic                       flags_we,
  output logic [5:0]                 flags,
  output logic                       inv_exc,
  output logic                       inv_sticky
);
  localparam int W   = 1 + EXP_W + MAN_W;
  localparam int MSB = W - 1;

  logic a_nan, b_nan, a_snan, b_snan, a_zero, b_zero;
  logic unord, eq, gt, inv_raw, do_write;
  logic [W-1:0] key_a, key_b;
  logic [2:0] code;

  assign a_nan  = (&op_a[MSB-1 -: EXP_W]) & (|op_a[MAN_W-1:0]);
  assign b_nan  = (&op_b[MSB-1 -: EXP_W]) & (|op_b[MAN_W-1:0]);
  assign a_snan = a_nan & ~op_a[MAN_W-1];
  assign b_snan = b_nan & ~op_b[MAN_W-1];
  assign a_zero = ~|op_a[MSB-1:0];
  assign b_zero = ~|op_b[MSB-1:0];

  assign key_a = op_a[MSB] ? ~op_a : {1'b1, op_a[MSB-1:0]};
  assign key_b = op_b[MSB] ? ~op_b : {1'b1, op_b[MSB-1:0]};

  assign unord    = a_nan | b_nan;
  assign eq       = (a_zero & b_zero) | (op_a == op_b);
  assign gt       = key_a > key_b;
  assign code     = unord ? 3'b111 : eq ? 3'b100 : gt ? 3'b000 : 3'b001;
  assign inv_raw  = unord_mode ? (a_snan | b_snan) : unord;
  assign do_write = in_valid & (~inv_raw | inv_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      flags_we   <= 1'b0;
      inv_exc    <= 1'b0;
      flags      <= '0;
      inv_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      flags_we  <= do_write;
      inv_exc   <= in_valid & inv_raw;
      if (do_write) flags <= {3'b000, code};
      if (in_valid & inv_raw) inv_sticky <= 1'b1;
      else if (sticky_clr)    inv_sticky <= 1'b0;
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> flags[5:3] == 3'b000); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (flags[2:0] inside {3'b000, 3'b001, 3'b100, 3'b111})); // R2
  AST_WE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we | inv_exc) |-> out_valid); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_HOLD_ON_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & ~flags_we) |-> $stable(flags)); // R6
  AST_EXC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_exc |-> inv_sticky); // R7
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inv_sticky) |-> $past(sticky_clr)); // R7
endmodule

// File: tb/sim_fcmp_flags.sv
module sim_fcmp_flags;
  logic clk = 0, rst_n = 0, in_valid = 0, unord_mode = 0, inv_mask = 0, sticky_clr = 0;
  logic [31:0] op_a = '0, op_b = '0;
  logic out_valid, flags_we, inv_exc, inv_sticky;
  logic [5:0] flags;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  fcmp_flags u0 (.clk, .rst_n, .in_valid, .op_a, .op_b, .unord_mode, .inv_mask,
                 .sticky_clr, .out_valid, .flags_we, .flags, .inv_exc, .inv_sticky);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp(logic [31:0] a, logic [31:0] b, logic mode, logic mask,
                     logic [5:0] exp_flags, logic exp_we, logic exp_exc, string req);
    @(negedge clk);
    op_a = a; op_b = b; unord_mode = mode; inv_mask = mask; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " R9 out_valid"}, {7'd0, out_valid}, 8'd1);
    chk({req, " flags"}, {2'd0, flags}, {2'd0, exp_flags});
    chk({req, " R6 flags_we"}, {7'd0, flags_we}, {7'd0, exp_we});
    chk({req, " inv_exc"}, {7'd0, inv_exc}, {7'd0, exp_exc});
  endtask

  task automatic t_reset();
    chk("R10 flags", {2'd0, flags}, 8'd0);
    chk("R10 status", {4'd0, out_valid, flags_we, inv_exc, inv_sticky}, 8'd0);
  endtask

  task automatic t_order();
    cmp(32'h40000000, 32'h3f800000, 0, 0, 6'b000000, 1, 0, "R2 gt");
    cmp(32'h3f800000, 32'h40000000, 0, 0, 6'b000001, 1, 0, "R2 lt");
    cmp(32'h3f800000, 32'h3f800000, 0, 0, 6'b000100, 1, 0, "R2 eq");
    cmp(32'hbf800000, 32'h3f800000, 0, 0, 6'b000001, 1, 0, "R2 neg<pos");
    cmp(32'hc0000000, 32'hbf800000, 0, 0, 6'b000001, 1, 0, "R2 -2<-1");
    cmp(32'hbf800000, 32'hc0000000, 0, 0, 6'b000000, 1, 0, "R3 R2 -1>-2");
    @(negedge clk);
    chk("R9 out_valid drops", {7'd0, out_valid}, 8'd0);
  endtask

  task automatic t_special();
    cmp(32'h00000000, 32'h80000000, 0, 0, 6'b000100, 1, 0, "R8 +0=-0");
    cmp(32'h00000001, 32'h00000000, 0, 0, 6'b000000, 1, 0, "R8 sub>0");
    cmp(32'h80000001, 32'h00000000, 0, 0, 6'b000001, 1, 0, "R8 -sub<0");
    cmp(32'h7f800000, 32'h7f7fffff, 0, 0, 6'b000000, 1, 0, "R8 inf>max");
    cmp(32'hff800000, 32'hff7fffff, 0, 0, 6'b000001, 1, 0, "R8 -inf<-max");
    cmp(32'h7f800000, 32'h7f800000, 0, 0, 6'b000100, 1, 0, "R8 inf=inf");
  endtask

  task automatic t_nan();
    chk("R7 sticky clean", {7'd0, inv_sticky}, 8'd0);
    cmp(32'h7fc00000, 32'h3f800000, 0, 1, 6'b000111, 1, 1, "R4 R1 R7 qnan masked");
    chk("R7 sticky set", {7'd0, inv_sticky}, 8'd1);
    cmp(32'h3f800000, 32'h40000000, 0, 0, 6'b000001, 1, 0, "R2 after nan");
    chk("R7 sticky persists", {7'd0, inv_sticky}, 8'd1);
    @(negedge clk); sticky_clr = 1;
    @(negedge clk); sticky_clr = 0;
    chk("R7 sticky cleared", {7'd0, inv_sticky}, 8'd0);
    cmp(32'h3f800000, 32'hffc00000, 1, 0, 6'b000111, 1, 0, "R5 R1 qnan unord");
    chk("R5 no sticky", {7'd0, inv_sticky}, 8'd0);
    cmp(32'h40000000, 32'h3f800000, 0, 0, 6'b000000, 1, 0, "R2 preload");
    cmp(32'h7f800001, 32'h3f800000, 1, 0, 6'b000000, 0, 1, "R5 R6 snan unord");
    chk("R7 sticky unmasked", {7'd0, inv_sticky}, 8'd1);
    cmp(32'h3f800000, 32'h7fc00000, 0, 0, 6'b000000, 0, 1, "R4 R6 qnan ordered");
    cmp(32'h3f800000, 32'h7f800001, 1, 1, 6'b000111, 1, 1, "R7 snan masked");
  endtask

  task automatic t_clr_race();
    @(negedge clk);
    op_a = 32'h7fc00000; op_b = 0; unord_mode = 0; inv_mask = 1; in_valid = 1; sticky_clr = 1;
    @(negedge clk);
    in_valid = 0; sticky_clr = 0;
    chk("R7 set beats clear", {7'd0, inv_sticky}, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_special();
    t_nan();
    t_clr_race();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule